// File: doc/BRIEF.md
# Serial Memory Control-Byte Decoder

This block is the two-wire slave front end of a small serial memory. It follows the clock and data lines of the bus and finds Start and Stop conditions. The first byte after a Start is read in as a control byte, most significant bit first. The block compares the top four bits of that byte with a fixed device code. It compares the next three bits with strapped chip-select levels, or skips that comparison when it is configured not to check them. If the byte matches, the block pulls the data line low for the acknowledge clock and reports the transfer direction.

For a write, the block takes in the next byte as the low eight bits of the word address and acknowledges it. The three chip-select bits of the control byte form the upper address bits. A step input moves the low byte on for sequential access. The low byte wraps within its own eight bits and never carries into the chip-select bits. The memory array, page buffering and read-data shifting belong to neighbouring logic.

Both bus lines pass through a two-stage synchroniser before any edge is detected. The data line is driven only as an open-drain output enable.

Top module: `eeprom_ctl_decoder`

## Requirements
- R1: Only the first byte after a Start condition (data falling while clock high) is decoded as a control byte. Bytes clocked in with no Start before them never produce an acknowledge.
- R2: The control byte matches only when its bits 7..4 equal binary 1010. On any other value, sda_oe stays low and selected stays 0.
- R3: When cs_check_en is 1, control bits 3, 2 and 1 (the chip-select bits, highest first) must equal strap_cs[2], strap_cs[1] and strap_cs[0] for a match.
- R4: When cs_check_en is 0, the chip-select bits are not compared, and any value of them matches.
- R5: When narrow_pkg is 1, strap_cs[2] is treated as 0. A control byte then needs bit 3 = 0 to match while cs_check_en is 1.
- R6: Control bit 0 gives the direction: 1 is a read (is_read = 1) and 0 is a write (is_read = 0). is_read does not change while selected is 1.
- R7: After a matching byte, sda_oe goes high after the falling clock edge that ends the eighth bit, stays high through the ninth clock, and goes low after the ninth falling edge. sda_oe is never high while selected is 0.
- R8: For a write, the byte after the control byte is stored as word_addr[7:0] and acknowledged, and addr_valid becomes 1. word_addr[10:8] holds control bits 3..1. addr_valid is never 1 for a read.
- R9: A one-cycle addr_step pulse, while selected is 1 and either is_read or addr_valid is 1, adds one to word_addr[7:0]. The step wraps from 0xFF to 0x00 and leaves word_addr[10:8] unchanged.
- R10: A Start or a Stop aborts any byte in progress. A Start clears sda_oe, selected, addr_valid and word_addr, and begins a new control byte. A Stop returns the block to idle and keeps the decoded results.
- R11: After reset, sda_oe, selected, is_read and addr_valid are 0 and word_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| strap_cs | input | 3 | Strapped chip-select levels, bit 2 highest |
| cs_check_en | input | 1 | 1 compares the chip-select bits, 0 ignores them |
| narrow_pkg | input | 1 | 1 treats strap_cs[2] as 0 |
| addr_step | input | 1 | One-cycle pulse that advances the low address byte |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| selected | output | 1 | The last control byte matched |
| is_read | output | 1 | Direction of the selected transfer |
| word_addr | output | 11 | {chip-select bits, low address byte} |
| addr_valid | output | 1 | The low address byte was captured for a write |

## Verification
A Start condition and the shifting of a data bit can reach the decoder in the same cycle when the master issues a repeated Start partway through a byte. The Start must win: the bit counter restarts, and no acknowledge may come from the aborted bits. The bench sends four bits of a control byte, raises a new Start, and then sends a full matching read byte. It judges the result by an acknowledge only on the ninth clock of the new byte and by is_read taken from that byte alone. A second run aborts with a Stop after three bits and then clocks a byte with no Start, which must stay unacknowledged.

// File: rtl/eeprom_ctl_pkg.sv
package eeprom_ctl_pkg;

    localparam int CODE_W = 4;
    localparam int CS_W   = 3;
    localparam int BYTE_W = CODE_W + CS_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int WA_W   = CS_W + BYTE_W;

    localparam logic [CODE_W-1:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_CACK,
        PH_ADDR,
        PH_AACK,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    // Device code must match; chip-select bits compared only when enabled.
    function automatic logic ctl_match(
        input logic [BYTE_W-1:0] ctl,
        input logic [CS_W-1:0]   strap,
        input logic              cmp_en,
        input logic              narrow
    );
        logic [CS_W-1:0] eff;
        eff = strap;
        if (narrow) eff[CS_W-1] = 1'b0;
        return (ctl[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
               (!cmp_en || (ctl[CS_W:1] == eff));
    endfunction

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync
    import eeprom_ctl_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC_N-1:0] scl_sh;
    logic [SYNC_N-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_N-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_N-2:0], sda_in};
            scl_q  <= scl_sh[SYNC_N-1];
            sda_q  <= sda_sh[SYNC_N-1];
        end
    end

    always_comb begin
        scl_s       = scl_sh[SYNC_N-1];
        sda_s       = sda_sh[SYNC_N-1];
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/eeprom_byte_fsm.sv
module eeprom_byte_fsm
    import eeprom_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [CS_W-1:0]   strap_cs,
    input  logic              cs_check_en,
    input  logic              narrow_pkg,
    output logic              sda_oe,
    output logic              selected,
    output logic              is_read,
    output logic [CS_W-1:0]   cs_bits,
    output logic              ld,
    output logic [BYTE_W-1:0] data
);
    phase_t            ph;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              full;

    assign data = sh;
    assign full = (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            sh       <= '0;
            sda_oe   <= 1'b0;
            selected <= 1'b0;
            is_read  <= 1'b0;
            cs_bits  <= '0;
            ld       <= 1'b0;
        end else begin
            ld <= 1'b0;
            if (ev.start) begin
                ph       <= PH_CTRL;
                cnt      <= '0;
                sda_oe   <= 1'b0;
                selected <= 1'b0;
                is_read  <= 1'b0;
                cs_bits  <= '0;
            end else if (ev.stop) begin
                ph     <= PH_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (ph)
                    PH_CTRL, PH_ADDR: begin
                        if (ev.scl_rise && !full) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && full) begin
                            cnt <= '0;
                            if (ph == PH_ADDR) begin
                                sda_oe <= 1'b1;
                                ld     <= 1'b1;
                                ph     <= PH_AACK;
                            end else if (ctl_match(sh, strap_cs, cs_check_en, narrow_pkg)) begin
                                sda_oe   <= 1'b1;
                                selected <= 1'b1;
                                is_read  <= sh[0];
                                cs_bits  <= sh[CS_W:1];
                                ph       <= PH_CACK;
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end
                    end
                    PH_CACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            ph     <= is_read ? PH_HOLD : PH_ADDR;
                        end
                    end
                    PH_AACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            ph     <= PH_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_addr_reg.sv
module eeprom_addr_reg #(
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            ld,
    input  logic [LO_W-1:0] d,
    input  logic            step,
    output logic [LO_W-1:0] lo,
    output logic            valid
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo    <= '0;
            valid <= 1'b0;
        end else if (ld) begin
            lo    <= d;
            valid <= 1'b1;
        end else if (step) begin
            lo <= lo + 1'b1;   // wraps inside LO_W bits
        end
    end
endmodule

// File: rtl/eeprom_ctl_decoder.sv
module eeprom_ctl_decoder
    import eeprom_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_in,
    input  logic            sda_in,
    input  logic [CS_W-1:0] strap_cs,
    input  logic            cs_check_en,
    input  logic            narrow_pkg,
    input  logic            addr_step,
    output logic            sda_oe,
    output logic            selected,
    output logic            is_read,
    output logic [WA_W-1:0] word_addr,
    output logic            addr_valid
);
    bus_ev_t           ev;
    logic [CS_W-1:0]   cs_bits;
    logic              ld;
    logic [BYTE_W-1:0] data;
    logic [BYTE_W-1:0] lo;
    logic              step_en;

    eeprom_bus_sync #(.SYNC_N(2)) sync_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    eeprom_byte_fsm fsm_i (
        .clk(clk), .rst(rst), .ev(ev),
        .strap_cs(strap_cs), .cs_check_en(cs_check_en), .narrow_pkg(narrow_pkg),
        .sda_oe(sda_oe), .selected(selected), .is_read(is_read),
        .cs_bits(cs_bits), .ld(ld), .data(data)
    );

    assign step_en = selected && (is_read || addr_valid);

    eeprom_addr_reg #(.LO_W(BYTE_W)) addr_i (
        .clk(clk), .rst(rst), .clr(ev.start), .ld(ld), .d(data),
        .step(addr_step && step_en), .lo(lo), .valid(addr_valid)
    );

    assign word_addr = {cs_bits, lo};

endmodule

// File: rtl/eeprom_ctl_decoder_chk.sv
module eeprom_ctl_decoder_chk
    import eeprom_ctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            sda_oe,
    input logic            selected,
    input logic            is_read,
    input logic            addr_valid,
    input logic [WA_W-1:0] word_addr,
    input logic            addr_step,
    input logic            step_en,
    input logic            ev_start,
    input logic            ev_scl_fall
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R11: outputs are idle in the cycle after reset
    always @(posedge clk) begin
        if (rst_q) begin
            a_r11_reset_idle: assert (!sda_oe && !selected && !addr_valid && word_addr == '0);
        end
    end

    a_r7_oe_needs_sel: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> selected);

    a_r7_oe_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev_scl_fall));

    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (!sda_oe && !selected && !addr_valid));

    a_r8_valid_write_only: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> !is_read);

    a_r6_dir_stable: assert property (@(posedge clk) disable iff (rst)
        (selected && !ev_start) |=> $stable(is_read));

    a_r9_wrap_local: assert property (@(posedge clk) disable iff (rst)
        (addr_step && step_en && !ev_start && word_addr[BYTE_W-1:0] == '1)
        |=> (word_addr[BYTE_W-1:0] == '0 && $stable(word_addr[WA_W-1:BYTE_W])));

endmodule

bind eeprom_ctl_decoder eeprom_ctl_decoder_chk chk_i (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .selected(selected),
    .is_read(is_read), .addr_valid(addr_valid), .word_addr(word_addr),
    .addr_step(addr_step), .step_en(step_en),
    .ev_start(ev.start), .ev_scl_fall(ev.scl_fall)
);

// File: tb/eeprom_ctl_decoder_tb_top.sv
module eeprom_ctl_decoder_tb_top;

    localparam int H = 5;
    localparam int NV = 9;
    // {ctrl[20:13], addr[12:5], strap[4:2], cs_check_en[1], narrow_pkg[0]}
    localparam logic [20:0] VEC [NV] = '{
        {8'hA0, 8'h3C, 3'b000, 1'b1, 1'b0},
        {8'hA7, 8'h00, 3'b011, 1'b1, 1'b0},
        {8'hAA, 8'h11, 3'b100, 1'b1, 1'b0},
        {8'hAA, 8'h5A, 3'b100, 1'b0, 1'b0},
        {8'hB0, 8'h22, 3'b000, 1'b0, 1'b0},
        {8'h28, 8'h33, 3'b100, 1'b1, 1'b0},
        {8'hA9, 8'h44, 3'b100, 1'b1, 1'b1},
        {8'hA1, 8'h00, 3'b100, 1'b1, 1'b1},
        {8'hAE, 8'hFF, 3'b111, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap_cs = 3'b000;
    logic        cs_check_en = 1'b1;
    logic        narrow_pkg = 1'b0;
    logic        addr_step = 1'b0;
    logic        sda_oe, selected, is_read, addr_valid;
    logic [10:0] word_addr;
    logic        sda_line;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_ctl_decoder dut_i (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .strap_cs(strap_cs), .cs_check_en(cs_check_en), .narrow_pkg(narrow_pkg),
        .addr_step(addr_step), .sda_oe(sda_oe), .selected(selected),
        .is_read(is_read), .word_addr(word_addr), .addr_valid(addr_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(H); scl = 1'b1; w(H); sda_m = 1'b0; w(H); scl = 1'b0; w(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(H); scl = 1'b1; w(H); sda_m = 1'b1; w(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; w(H); scl = 1'b1; w(H); scl = 1'b0; w(H);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic late);
        send_bits(b, 8);
        sda_m = 1'b1; w(H); scl = 1'b1; w(3); ack = sda_oe; w(2); scl = 1'b0; w(H);
        late = sda_oe;
    endtask

    function automatic logic exp_hit(input logic [7:0] c, input logic [2:0] s,
                                     input logic cmp, input logic nar);
        logic [2:0] e;
        e = {nar ? 1'b0 : s[2], s[1:0]};
        return (c[7:4] == 4'b1010) && (!cmp || c[3:1] == e);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack, late;
        logic [7:0] c, a;
        logic hit;
        w(4);
        // R11 reset state
        chk("R11 sda_oe", {31'b0, sda_oe}, 0);
        chk("R11 selected", {31'b0, selected}, 0);
        chk("R11 addr_valid", {31'b0, addr_valid}, 0);
        chk("R11 word_addr", {21'b0, word_addr}, 0);
        rst = 1'b0; w(4);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            c = VEC[k][20:13]; a = VEC[k][12:5];
            strap_cs = VEC[k][4:2]; cs_check_en = VEC[k][1]; narrow_pkg = VEC[k][0];
            hit = exp_hit(c, strap_cs, cs_check_en, narrow_pkg);
            bus_start();
            send_byte(c, ack, late);
            chk("R2/R3/R4/R5 control ack", {31'b0, ack}, {31'b0, hit});
            chk("R7 ack released", {31'b0, late}, 0);
            if (hit && !c[0]) begin
                send_byte(a, ack, late);
                chk("R8 address ack", {31'b0, ack}, 1);
                chk("R7 addr ack released", {31'b0, late}, 0);
            end
            bus_stop(); w(4);
            chk("R2 selected", {31'b0, selected}, {31'b0, hit});
            if (hit) begin
                chk("R6 direction", {31'b0, is_read}, {31'b0, c[0]});
                chk("R8 addr_valid", {31'b0, addr_valid}, {31'b0, !c[0]});
                if (!c[0]) chk("R8 word_addr", {21'b0, word_addr}, {21'b0, c[3:1], a});
            end else begin
                chk("R2 addr_valid idle", {31'b0, addr_valid}, 0);
            end
        end

        // R9: last vector left {111, FF}; step wraps low byte only
        @(negedge clk) addr_step = 1'b1;
        @(negedge clk) addr_step = 1'b0;
        w(2);
        chk("R9 wrap", {21'b0, word_addr}, {21'b0, 3'b111, 8'h00});
        @(negedge clk) addr_step = 1'b1;
        @(negedge clk) addr_step = 1'b0;
        w(2);
        chk("R9 increment", {21'b0, word_addr}, {21'b0, 3'b111, 8'h01});

        // R10: repeated Start in mid byte, then a fresh matching read
        strap_cs = 3'b000; cs_check_en = 1'b1; narrow_pkg = 1'b0;
        bus_start();
        send_bits(8'hB0, 4);
        bus_start();
        chk("R10 start cleared selected", {31'b0, selected}, 0);
        chk("R10 start cleared addr_valid", {31'b0, addr_valid}, 0);
        send_byte(8'hA1, ack, late);
        chk("R10 ack after restart", {31'b0, ack}, 1);
        bus_stop(); w(4);
        chk("R10 read after restart", {31'b0, is_read}, 1);
        chk("R10 word_addr cleared", {21'b0, word_addr}, 0);

        // R1/R10: Stop aborts a byte; a byte with no Start is not acknowledged
        bus_start();
        send_bits(8'hA0, 3);
        bus_stop();
        scl = 1'b0; w(H);
        send_byte(8'hA0, ack, late);
        chk("R1 no ack without start", {31'b0, ack}, 0);
        chk("R1 still unselected", {31'b0, selected}, 0);
        bus_stop(); w(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule